// File: doc/BRIEF.md
# Pointer Code Insert and Check Unit

This unit signs, checks or cleans a 64-bit pointer by using the upper bits that a 48-bit virtual address leaves free. Each request carries a pointer, a 64-bit modifier, a one-bit key index and an operation code. On every request the unit first canonicalises the pointer. For the add and authenticate operations it then sends the canonical pointer, the modifier and the key to an external cipher over a valid/ready request channel. It waits for the 64-bit code on a valid/ready response channel. After that it either inserts the code into the pointer's code field or compares the code with the code the pointer already holds.

The range-select bit (bit 55) marks the upper or lower address half. This bit is never part of the code field, and it survives every operation unchanged. A failed check does not raise a fault. Instead it returns a poisoned pointer that carries a key-specific error pattern, so that any later use of the pointer faults. The strip operation removes a code without any cipher traffic. The cipher itself is outside the block.

Top module: `pac_unit`

## Requirements
- R1: Out of reset, `done`, `cph_valid` and `rsp_ready` are 0 and `req_ready` is 1. `req_ready` is never 1 while `cph_valid` or `rsp_ready` is 1.
- R2: The code field is bits 54:48. Bit 55 is outside the field. Operation codes are 2'b00 add, 2'b01 authenticate, 2'b10 strip; 2'b11 behaves as strip. Strip returns the canonical pointer: field bits cleared when bit 55 is 0 and all set when bit 55 is 1. Its `done` pulse comes in the cycle after the request is accepted, with no cipher request.
- R3: For add and authenticate, the cipher request carries the canonical pointer, the modifier and the key index. The add result is the code's bits 54:48, with the pointer's own bits everywhere else, so bit 55 is preserved.
- R4: In an add, if pointer bits 55:48 are neither all zero nor all one, bit 54 of the code is inverted before it is inserted.
- R5: Authenticate returns the canonical pointer when the code's bits 54:48 equal the pointer's bits 54:48.
- R6: On an authenticate mismatch, the result is the canonical pointer with bits 54:53 set to 2'b01 for key 0 and to 2'b10 for key 1. Example: 0x0020000012345678 is returned for a tampered key-0 pointer whose canonical value is 0x12345678.
- R7: For add and authenticate, `done` pulses for one cycle, in the cycle after the cipher response is accepted. `result` changes only in a `done` cycle and holds its value afterwards.
- R8: Request inputs are captured when accepted. Changing them during the operation has no effect. A pending cipher request keeps its valid signal and its payload stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_op | input | 2 | Operation code (see R2) |
| req_key | input | 1 | Key index, 0 or 1 |
| req_ptr | input | 64 | Pointer to transform |
| req_mod | input | 64 | Modifier |
| cph_valid | output | 1 | Cipher request valid |
| cph_ready | input | 1 | Cipher request accepted |
| cph_ptr | output | 64 | Canonical pointer to the cipher |
| cph_mod | output | 64 | Modifier to the cipher |
| cph_key | output | 1 | Key index to the cipher |
| rsp_valid | input | 1 | Cipher code valid |
| rsp_ready | output | 1 | Unit waiting for the code |
| rsp_code | input | 64 | Code from the cipher |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Transformed pointer, held until the next completion |

## Verification
A strip result is due in the cycle right after acceptance. The cipher request is due in that same cycle, and an add or authenticate result is due in the cycle after the response handshake. The bench drives and samples on falling edges and counts those cycles exactly. It inserts random stalls on both cipher channels and checks that `done` stays low until the due cycle. It then checks that `done` falls again one cycle later while `result` holds. Request inputs are scrambled right after acceptance, so any late sampling shows up in the captured cipher payload or in the result.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    OP_ADD      = 2'b00,
    OP_AUTH     = 2'b01,
    OP_STRIP    = 2'b10,
    OP_STRIP_X  = 2'b11
  } pac_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CREQ  = 2'd1,
    ST_CWAIT = 2'd2
  } pac_state_e;
endpackage

// File: rtl/pac_canon.sv
module pac_canon #(
  parameter int PTR_W   = 64,
  parameter int VA_BITS = 48,
  parameter int SEL_BIT = 55
) (
  input  logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] mask,
  output logic [PTR_W-1:0] canon,
  output logic             mixed
);
  localparam int HI_W = SEL_BIT - VA_BITS + 1;

  logic [HI_W-1:0] hi_bits;

  for (genvar i = 0; i < PTR_W; i++) begin : g_mask
    if (i >= VA_BITS && i < SEL_BIT) begin : g_in
      assign mask[i] = 1'b1;
    end else begin : g_out
      assign mask[i] = 1'b0;
    end
  end

  assign hi_bits = ptr[SEL_BIT:VA_BITS];

  always_comb begin
    if (ptr[SEL_BIT]) canon = ptr | mask;
    else              canon = ptr & ~mask;
    mixed = (|hi_bits) && !(&hi_bits);
  end
endmodule

// File: rtl/pac_merge.sv
module pac_merge #(
  parameter int PTR_W   = 64,
  parameter int SEL_BIT = 55
) (
  input  logic             is_auth,
  input  logic             key,
  input  logic [PTR_W-1:0] ptr,
  input  logic [PTR_W-1:0] canon,
  input  logic [PTR_W-1:0] mask,
  input  logic             mixed,
  input  logic [PTR_W-1:0] code,
  output logic [PTR_W-1:0] merged
);
  logic [PTR_W-1:0] flip_vec;
  logic [PTR_W-1:0] code_adj;
  logic [PTR_W-1:0] poison;
  logic             match;

  always_comb begin
    flip_vec = '0;
    flip_vec[SEL_BIT-1] = mixed;
    code_adj = code ^ flip_vec;
    match    = ((code ^ ptr) & mask) == '0;
    poison   = canon;
    poison[SEL_BIT-1 -: 2] = key ? 2'b10 : 2'b01;
    if (!is_auth)   merged = (code_adj & mask) | (ptr & ~mask);
    else if (match) merged = canon;
    else            merged = poison;
  end
endmodule

// File: rtl/pac_unit.sv
module pac_unit
  import pac_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int VA_BITS = 48,
  parameter int SEL_BIT = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic             req_key,
  input  logic [PTR_W-1:0] req_ptr,
  input  logic [PTR_W-1:0] req_mod,
  output logic             cph_valid,
  input  logic             cph_ready,
  output logic [PTR_W-1:0] cph_ptr,
  output logic [PTR_W-1:0] cph_mod,
  output logic             cph_key,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [PTR_W-1:0] rsp_code,
  output logic             done,
  output logic [PTR_W-1:0] result
);
  localparam int HI_W = SEL_BIT - VA_BITS + 1;

  pac_state_e       state_q, state_d;
  logic             op_auth_q;
  logic             key_q;
  logic [PTR_W-1:0] ptr_q, mod_q, result_q, result_d;
  logic             done_q, done_d;
  logic             req_fire, is_strip, rsp_fire, cap_en, res_en;
  logic [PTR_W-1:0] canon_src, canon, mask, merged;
  logic             mixed;

  assign req_ready = (state_q == ST_IDLE);
  assign cph_valid = (state_q == ST_CREQ);
  assign rsp_ready = (state_q == ST_CWAIT);
  assign req_fire  = req_valid && req_ready;
  assign is_strip  = req_op[1];
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign cap_en    = req_fire;
  assign res_en    = (req_fire && is_strip) || rsp_fire;

  assign canon_src = req_ready ? req_ptr : ptr_q;

  pac_canon #(.PTR_W(PTR_W), .VA_BITS(VA_BITS), .SEL_BIT(SEL_BIT)) u_canon (
    .ptr(canon_src), .mask(mask), .canon(canon), .mixed(mixed)
  );

  pac_merge #(.PTR_W(PTR_W), .SEL_BIT(SEL_BIT)) u_merge (
    .is_auth(op_auth_q), .key(key_q), .ptr(ptr_q), .canon(canon),
    .mask(mask), .mixed(mixed), .code(rsp_code), .merged(merged)
  );

  always_comb begin
    state_d  = state_q;
    result_d = result_q;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_fire) begin
        if (is_strip) begin
          result_d = canon;
          done_d   = 1'b1;
        end else begin
          state_d = ST_CREQ;
        end
      end
      ST_CREQ: if (cph_ready) state_d = ST_CWAIT;
      ST_CWAIT: if (rsp_fire) begin
        result_d = merged;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_auth_q <= 1'b0;
      key_q     <= 1'b0;
      ptr_q     <= '0;
      mod_q     <= '0;
    end else if (cap_en) begin
      op_auth_q <= req_op[0];
      key_q     <= req_key;
      ptr_q     <= req_ptr;
      mod_q     <= req_mod;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (res_en) result_q <= result_d;
  end

  assign cph_ptr = canon;
  assign cph_mod = mod_q;
  assign cph_key = key_q;
  assign done    = done_q;
  assign result  = result_q;

  // R1
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (cph_valid || rsp_ready)));

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rsp_valid && rsp_ready) || $past(req_valid && req_ready && req_op[1])));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R8
  cph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cph_valid && !cph_ready) |=> (cph_valid && $stable(cph_ptr) && $stable(cph_mod) && $stable(cph_key)));

  // R3
  sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[SEL_BIT] == ptr_q[SEL_BIT]));

  // R2
  strip_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_op[1] && req_fire)) |->
      (result[SEL_BIT:VA_BITS] == '0 || result[SEL_BIT:VA_BITS] == {HI_W{1'b1}}));
endmodule

// File: tb/pac_unit_tb.sv
module pac_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] FMASK = 64'h007F_0000_0000_0000;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_key;
  logic [1:0]  req_op;
  logic [63:0] req_ptr, req_mod;
  logic        cph_valid, cph_ready, cph_key;
  logic [63:0] cph_ptr, cph_mod;
  logic        rsp_valid, rsp_ready;
  logic [63:0] rsp_code;
  logic        done;
  logic [63:0] result;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  pac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_key(req_key), .req_ptr(req_ptr), .req_mod(req_mod),
    .cph_valid(cph_valid), .cph_ready(cph_ready), .cph_ptr(cph_ptr),
    .cph_mod(cph_mod), .cph_key(cph_key), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_code(rsp_code), .done(done), .result(result)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] cipher(logic [63:0] d, logic [63:0] m, logic k);
    logic [63:0] x;
    x = d ^ {m[50:0], m[63:51]} ^ (k ? 64'h3c6e_f372_fe94_f82b : 64'h6a09_e667_bb67_ae85);
    x = x * 64'h9e37_79b9_7f4a_7c15;
    return x ^ (x >> 29);
  endfunction

  function automatic logic [63:0] canon_of(logic [63:0] p);
    return p[55] ? (p | FMASK) : (p & ~FMASK);
  endfunction

  function automatic logic is_mixed(logic [63:0] p);
    return (p[55:48] != 8'h00) && (p[55:48] != 8'hFF);
  endfunction

  function automatic logic [63:0] exp_add(logic [63:0] p, logic [63:0] m, logic k);
    logic [63:0] c;
    c = cipher(canon_of(p), m, k);
    if (is_mixed(p)) c[54] = ~c[54];
    return (c & FMASK) | (p & ~FMASK);
  endfunction

  function automatic logic auth_ok(logic [63:0] p, logic [63:0] m, logic k);
    return ((cipher(canon_of(p), m, k) ^ p) & FMASK) == 64'd0;
  endfunction

  function automatic logic [63:0] exp_auth(logic [63:0] p, logic [63:0] m, logic k);
    logic [63:0] c;
    c = canon_of(p);
    if (!auth_ok(p, m, k)) c[54:53] = k ? 2'b10 : 2'b01;
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic k, input logic [63:0] p,
                        input logic [63:0] m, input int cd, input int rd,
                        output logic [63:0] res);
    logic [63:0] expv;
    string tag;
    bit seen_early;
    chk(req_ready == 1'b1, "R1", {63'd0, req_ready}, 64'd1);
    req_valid = 1; req_op = op; req_key = k; req_ptr = p; req_mod = m;
    @(negedge clk);
    req_valid = 0; req_op = ~op; req_key = ~k; req_ptr = ~p; req_mod = ~m;
    if (op[1]) begin
      expv = canon_of(p);
      chk(done == 1'b1 && cph_valid == 1'b0, "R2", {62'd0, done, cph_valid}, 64'd2);
      chk(result == expv, "R2", result, expv);
    end else begin
      chk(cph_valid && cph_ptr == canon_of(p), "R3", cph_ptr, canon_of(p));
      chk(cph_mod == m && cph_key == k, "R8", cph_mod, m);
      seen_early = 0;
      for (int i = 0; i < cd; i++) begin
        @(negedge clk);
        if (!cph_valid || cph_ptr != canon_of(p) || done) seen_early = 1;
      end
      chk(!seen_early, "R8", {63'd0, seen_early}, 64'd0);
      cph_ready = 1;
      @(negedge clk);
      cph_ready = 0;
      chk(rsp_ready == 1'b1 && cph_valid == 1'b0, "R1", {62'd0, rsp_ready, cph_valid}, 64'd2);
      seen_early = 0;
      for (int i = 0; i < rd; i++) begin
        @(negedge clk);
        if (done) seen_early = 1;
      end
      chk(!seen_early && !done, "R7", {63'd0, seen_early}, 64'd0);
      rsp_valid = 1; rsp_code = cipher(canon_of(p), m, k);
      @(negedge clk);
      rsp_valid = 0; rsp_code = 64'd0;
      chk(done == 1'b1, "R7", {63'd0, done}, 64'd1);
      if (op[0]) begin
        expv = exp_auth(p, m, k);
        tag = auth_ok(p, m, k) ? "R5" : "R6";
      end else begin
        expv = exp_add(p, m, k);
        tag = is_mixed(p) ? "R4" : "R3";
      end
      chk(result == expv, tag, result, expv);
    end
    res = result;
    @(negedge clk);
    chk(done == 1'b0 && result == res, "R7", result, res);
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [63:0] r, a0, a1, p, m;
    logic [1:0] op;
    logic k;
    int seed;
    seed = $urandom(32'h5eed_1234);
    req_valid = 0; req_op = 0; req_key = 0; req_ptr = 0; req_mod = 0;
    cph_ready = 0; rsp_valid = 0; rsp_code = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 0 && cph_valid == 0 && rsp_ready == 0 && req_ready == 1, "R1",
        {60'd0, done, cph_valid, rsp_ready, req_ready}, 64'd1);
    rst_n = 1;
    @(negedge clk);

    m = 64'h477d_469d_ec0b_8768;
    // R2 strip, lower half, garbage field
    run_op(2'b10, 0, 64'h0035_1234_5678_9abc, m, 0, 0, r);
    chk(r == 64'h0000_1234_5678_9abc, "R2", r, 64'h0000_1234_5678_9abc);
    // R2 strip, upper half
    run_op(2'b10, 1, 64'hff80_0000_1234_5678, m, 0, 0, r);
    chk(r == 64'hffff_0000_1234_5678, "R2", r, 64'hffff_0000_1234_5678);
    // R2 op 3 acts as strip
    run_op(2'b11, 0, 64'h0011_0000_0000_0040, m, 0, 0, r);
    // R3 add, canonical lower pointer, stalls
    run_op(2'b00, 0, 64'h0000_0000_1234_5678, m, 3, 2, a0);
    run_op(2'b00, 1, 64'h0000_0000_1234_5678, m, 0, 0, a1);
    // R3 add, canonical upper pointer
    run_op(2'b00, 0, 64'hffff_ffff_0000_1000, m, 1, 4, r);
    // R4 add, non-canonical pointers
    run_op(2'b00, 0, 64'h0001_0000_1234_5678, m, 2, 1, r);
    run_op(2'b00, 1, 64'h80fe_0000_0000_0010, m, 0, 3, r);
    // R5 authenticate success, both keys
    run_op(2'b01, 0, a0, m, 1, 1, r);
    chk(r == 64'h0000_0000_1234_5678, "R5", r, 64'h0000_0000_1234_5678);
    run_op(2'b01, 1, a1, m, 0, 2, r);
    chk(r == 64'h0000_0000_1234_5678, "R5", r, 64'h0000_0000_1234_5678);
    // R6 tampered pointer, key 0 and key 1
    run_op(2'b01, 0, a0 ^ 64'h0001_0000_0000_0000, m, 0, 0, r);
    chk(r == 64'h0020_0000_1234_5678, "R6", r, 64'h0020_0000_1234_5678);
    run_op(2'b01, 1, a1 ^ 64'h0001_0000_0000_0000, m, 2, 0, r);
    chk(r == 64'h0040_0000_1234_5678, "R6", r, 64'h0040_0000_1234_5678);
    // R6 wrong modifier
    run_op(2'b01, 0, a0, m ^ 64'd8, 0, 1, r);

    for (int n = 0; n < 60; n++) begin
      op = 2'($urandom_range(0, 3));
      k  = 1'($urandom_range(0, 1));
      p  = {$urandom, $urandom};
      m  = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) p = canon_of(p);
      if (op == 2'b01 && $urandom_range(0, 1) == 1) p = exp_add(p, m, k);
      run_op(op, k, p, m, $urandom_range(0, 3), $urandom_range(0, 3), r);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule